// File: doc/BRIEF.md
# Odd/Full Inversion Link Encoder with Decoder

This block cuts switching on a parallel on-chip link. For each accepted word it chooses one of three forms to send: the word as it is, the word with only its odd-indexed bits inverted, or the whole word inverted. The choice compares the incoming word with the payload that was last placed on the link. It looks at every pair of adjacent lines and sorts the pairs by how each form would change their switching. Two side-band mode bits go with the payload, so the receiving end can undo the transform exactly.

The encoded payload and the mode are held in a link register. This register is also the previous-word state that the next decision compares against. A decoder on the register output gives back the original word, so the round trip can be watched from a single instance.

Top module: `oddfull_link_codec`

## Requirements
- R1: While rst_n is low and after it rises, link_data is all zeros, link_mode is 00 and link_valid is 0 until the first accepted word.
- R2: On a rising clock edge with in_valid low, link_data and link_mode keep their values.
- R3: link_mode takes only the values 00 (no inversion), 01 (odd inversion) and 10 (full inversion). The value 11 never appears.
- R4: Each adjacent line pair (i, i+1), for i = 0..W-2, is compared between the previous link payload P and the incoming word D. A pair is single-change when exactly one of its two lines differs. It is opposite-change when both lines differ and D[i] != D[i+1]. It is full-harmful when neither line differs and P[i] != P[i+1]. Full inversion (mode 10) is chosen when the opposite-change count is greater than the full-harmful count and also greater than the single-change count.
- R5: Odd inversion (mode 01) is chosen when full inversion is not chosen and the single-change count is greater than (W-1)/2, rounded down.
- R6: When neither R4 nor R5 applies, the mode is 00 and the payload equals the incoming word.
- R7: In mode 01 the payload is the incoming word XOR a mask that has ones at the odd bit positions 1, 3, 5, .... In mode 10 the payload is the bitwise complement of the word.
- R8: dec_data always equals the last word accepted, recovered from link_data and link_mode.
- R9: link_valid is 1 in the cycle after an accepted word and 0 in the cycle after a clock edge with in_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Accept in_data on this edge |
| in_data | input | W | Word to send |
| link_data | output | W | Encoded payload held on the link |
| link_mode | output | 2 | Inversion mode of the held payload |
| link_valid | output | 1 | A word was accepted on the last edge |
| dec_data | output | W | Word recovered from the link |

## Verification
Full inversion is the hardest case to reach. It needs opposite-change pairs, and those exist only when the previous payload has unequal neighbours and the new word swaps them. Random data seldom produces more of them than single-change pairs. The stimulus gets there with a hand-built pair of words, 0x0F followed by 0xF0. It also sweeps every 8-bit value, each followed by that value XOR 0x3C, which creates many swapped-neighbour patterns. A reference model in the bench tracks the payload and predicts the mode and payload for every word.

// File: rtl/oddfull_link_codec.sv
module oddfull_link_codec #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic [W-1:0] link_data,
  output logic [1:0]   link_mode,
  output logic         link_valid,
  output logic [W-1:0] dec_data
);
  localparam int NP = W - 1;
  localparam int CW = $clog2(W) + 1;
  localparam logic [CW-1:0] HALF = CW'(NP / 2);
  localparam logic [1:0] M_NONE = 2'b00;
  localparam logic [1:0] M_ODD  = 2'b01;
  localparam logic [1:0] M_FULL = 2'b10;

  function automatic logic [W-1:0] mk_odd_mask();
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) m[i] = (i % 2) == 1;
    return m;
  endfunction
  localparam logic [W-1:0] ODD_MASK = mk_odd_mask();

  logic [W-1:0] chg;
  logic [NP-1:0] single_v, swap_v, hurt_v;
  logic [CW-1:0] n_single, n_swap, n_hurt;
  logic take_full, take_odd;
  logic [W-1:0] enc;
  logic [1:0] mode_nxt;

  assign chg = link_data ^ in_data;

  genvar g;
  generate
    for (g = 0; g < NP; g++) begin : g_pair
      assign single_v[g] = chg[g] ^ chg[g+1];
      assign swap_v[g]   = chg[g] & chg[g+1] & (in_data[g] ^ in_data[g+1]);
      assign hurt_v[g]   = ~chg[g] & ~chg[g+1] & (link_data[g] ^ link_data[g+1]);
    end
  endgenerate

  always_comb begin
    n_single = '0;
    n_swap   = '0;
    n_hurt   = '0;
    for (int i = 0; i < NP; i++) begin
      n_single = n_single + CW'(single_v[i]);
      n_swap   = n_swap   + CW'(swap_v[i]);
      n_hurt   = n_hurt   + CW'(hurt_v[i]);
    end
  end

  assign take_full = (n_swap > n_hurt) && (n_swap > n_single);
  assign take_odd  = !take_full && (n_single > HALF);
  assign mode_nxt  = take_full ? M_FULL : (take_odd ? M_ODD : M_NONE);
  assign enc       = take_full ? ~in_data : (take_odd ? (in_data ^ ODD_MASK) : in_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_data  <= '0;
      link_mode  <= M_NONE;
      link_valid <= 1'b0;
    end else begin
      link_valid <= in_valid;
      if (in_valid) begin
        link_data <= enc;
        link_mode <= mode_nxt;
      end
    end
  end

  always_comb begin
    case (link_mode)
      M_ODD:   dec_data = link_data ^ ODD_MASK;
      M_FULL:  dec_data = ~link_data;
      default: dec_data = link_data;
    endcase
  end
endmodule

module oddfull_link_codec_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [W-1:0] in_data,
  input logic [W-1:0] link_data,
  input logic [1:0]   link_mode,
  input logic         link_valid,
  input logic [W-1:0] dec_data
);
  function automatic logic [W-1:0] odd_bits();
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) m[i] = (i % 2) == 1;
    return m;
  endfunction
  localparam logic [W-1:0] OM = odd_bits();

  // R3
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_mode != 2'b11);
  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(link_data) && $stable(link_mode)));
  // R8
  round_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (dec_data == $past(in_data)));
  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> link_valid);
  // R6
  none_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((link_mode != 2'b00) || (link_data == $past(in_data))));
  // R7
  odd_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((link_mode != 2'b01) || (link_data == ($past(in_data) ^ OM))));
  // R7
  full_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((link_mode != 2'b10) || (link_data == ~$past(in_data))));
endmodule

bind oddfull_link_codec oddfull_link_codec_chk #(.W(W)) chk_i (.*);

// File: tb/oddfull_link_codec_test.sv
`timescale 1ns/1ps
module oddfull_link_codec_test;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic [W-1:0] link_data, dec_data;
  logic [1:0] link_mode;
  logic link_valid;

  int checks = 0;
  int errors = 0;
  int seen_none = 0, seen_odd = 0, seen_full = 0;
  logic [W-1:0] m_prev = '0;
  logic [1:0] m_mode = 2'b00;
  bit done = 0;

  oddfull_link_codec #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .link_data(link_data), .link_mode(link_mode), .link_valid(link_valid),
    .dec_data(dec_data)
  );

  always #2 clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] pick(input logic [W-1:0] p, input logic [W-1:0] d);
    int ns = 0, nw = 0, nh = 0;
    for (int i = 0; i < W - 1; i++) begin
      logic a, b;
      a = p[i] != d[i];
      b = p[i+1] != d[i+1];
      if (a != b) ns++;
      if (a && b && d[i] != d[i+1]) nw++;
      if (!a && !b && p[i] != p[i+1]) nh++;
    end
    if (nw > nh && nw > ns) return 2'b10;
    if (ns > (W - 1) / 2) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [W-1:0] form(input logic [1:0] m, input logic [W-1:0] d);
    logic [W-1:0] om;
    for (int i = 0; i < W; i++) om[i] = (i % 2) == 1;
    if (m == 2'b10) return ~d;
    if (m == 2'b01) return d ^ om;
    return d;
  endfunction

  task automatic send(input logic [W-1:0] d);
    logic [1:0] em;
    @(negedge clk);
    in_valid = 1'b1;
    in_data = d;
    em = pick(m_prev, d);
    @(negedge clk);
    in_valid = 1'b0;
    m_prev = form(em, d);
    m_mode = em;
    if (em == 2'b00) seen_none++;
    if (em == 2'b01) seen_odd++;
    if (em == 2'b10) seen_full++;
    chk("R4/R5/R6 mode", link_mode, em);
    chk("R7 payload", link_data, m_prev);
    chk("R8 decode", dec_data, d);
    chk("R9 valid", link_valid, 1'b1);
    chk("R3 legal", link_mode == 2'b11, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 data", link_data, '0);
    chk("R1 mode", link_mode, 2'b00);
    chk("R1 valid", link_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 data after release", link_data, '0);
    chk("R1 valid after release", link_valid, 1'b0);

    // R6 none from reset: 0x00 keeps all pairs idle
    send(8'h00);
    chk("R6 hand none", link_mode, 2'b00);
    // R5 odd: alternating word over all-zero payload gives 7 single-change pairs
    send(8'h55);
    chk("R5 hand odd", link_mode, 2'b01);
    chk("R7 hand odd payload", link_data, 8'hFF);
    // R4 full: 0x0F then 0xF0 makes one opposite-change pair, others same-direction
    send(8'h0F);
    chk("R6 hand none 0x0F", link_mode, 2'b00);
    send(8'hF0);
    chk("R4 hand full", link_mode, 2'b10);
    chk("R7 hand full payload", link_data, 8'h0F);

    // R2: idle edge with different data leaves the link unchanged
    @(negedge clk);
    in_data = 8'hA5;
    @(negedge clk);
    chk("R2 hold data", link_data, m_prev);
    chk("R2 hold mode", link_mode, m_mode);
    chk("R9 valid low", link_valid, 1'b0);
    chk("R8 decode held", dec_data, 8'hF0);

    for (int v = 0; v < 256; v++) begin
      send(W'(v));
      send(W'(v) ^ 8'h3C);
    end
    for (int k = 0; k < 1500; k++) send(W'($urandom));

    chk("R4 full seen", seen_full > 0, 1'b1);
    chk("R5 odd seen", seen_odd > 0, 1'b1);
    chk("R6 none seen", seen_none > 0, 1'b1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule